// File: doc/BRIEF.md
# Receive/Transmit DMA Channel Pair for a Serial Port

This block moves characters between one serial port and system memory without any processor work per character. It holds two independent channels: one drains received characters into memory, the other fetches characters from memory for sending. Each channel keeps a memory address pointer and a remaining-unit count. Software loads both over a small register bus. After that, every request edge from the port produces exactly one memory access. Each access advances the pointer and counts the remaining units down.

Only one memory access can be in progress per cycle. The receive side wins when both sides are waiting, so that received data is not lost. A read's data comes back one cycle after the request. It is then handed to the port with a one-cycle valid strobe. When a channel's count runs out it raises a sticky end-of-transfer flag. The port's interrupt logic uses that flag. The flag clears when software writes a new nonzero count.

Top module: `pdc_pair`

## Requirements
- R1: While reset is asserted and right after it, both pointers and counts read 0, both end-of-transfer flags are 0, and `mem_valid` and `tx_valid` are 0.
- R2: Register address bit 1 selects the channel (0 receive, 1 transmit) and bit 0 selects the field (0 pointer, 1 count). A write stores the pointer as 32 bits and the count from the low 16 data bits; the upper 16 bits are ignored. Readback returns the pointer, or the count zero-extended.
- R3: A rising edge on `rx_req` sampled while the receive count is nonzero produces one memory write (`mem_valid`=1, `mem_write`=1) in the next cycle. Its address is the receive pointer and its data is the `rx_data` sampled with the edge.
- R4: A rising edge on `tx_req` sampled while the transmit count is nonzero produces one memory read (`mem_write`=0) at the transmit pointer in the next free cycle. `mem_rdata` is taken one cycle after that read. It appears on `tx_data` with `tx_valid` high for exactly one cycle in the cycle after that.
- R5: Each completed access adds 1 to the pointer when `unit_wide`=0, or 2 when `unit_wide`=1, and subtracts 1 from the count.
- R6: The access that brings a count from 1 to 0 sets that channel's end-of-transfer flag. The flag stays set while the count remains 0.
- R7: While a channel's count is 0, its requests cause no memory access and leave its pointer unchanged. Writing a zero count cancels a request that has not yet been served.
- R8: Writing a nonzero count clears that channel's end-of-transfer flag and re-arms the channel.
- R9: A request held high for many cycles is served exactly once; a new access needs a new rising edge.
- R10: When both channels are waiting, the receive write goes out first and the transmit read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: bit 1 channel, bit 0 field |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback for `reg_addr` |
| unit_wide | input | 1 | Unit size: 0 one byte, 1 two bytes |
| rx_req | input | 1 | Receive-ready request from the port |
| rx_data | input | 16 | Received character, sampled with the request edge |
| tx_req | input | 1 | Transmit-ready request from the port |
| tx_data | output | 16 | Character fetched for sending |
| tx_valid | output | 1 | One-cycle strobe qualifying `tx_data` |
| rx_done | output | 1 | Receive end-of-transfer flag |
| tx_done | output | 1 | Transmit end-of-transfer flag |
| mem_valid | output | 1 | Memory access request this cycle |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read |

## Verification
A request edge sampled at one clock edge shows up on the memory port in the following cycle. The pointer, count and end-of-transfer flag change at the edge that ends that access. Fetched transmit data reaches `tx_data` two edges after the read. The bench runs a behavioural model that steps at each rising edge from the same inputs. It compares every output a quarter period later, so each result is checked in the cycle it is due. Directed checks then count memory accesses across held requests, simultaneous requests and zero-count requests.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;

  typedef enum logic {
    FLD_PTR = 1'b0,
    FLD_CNT = 1'b1
  } fld_sel_e;
endpackage

// File: rtl/pdc_channel.sv
module pdc_channel #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          grant,
  input  logic          wr_ptr,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wdata,
  input  logic [1:0]    step,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          pend,
  output logic          done,
  output logic          rise
);
  logic          req_q;
  logic [AW-1:0] ptr_n;
  logic [CW-1:0] cnt_n;
  logic          pend_n, done_n;
  logic          ptr_en, cnt_en;

  assign rise   = req & ~req_q;
  assign ptr_en = grant | wr_ptr;
  assign cnt_en = grant | wr_cnt;

  always_comb begin
    ptr_n  = ptr;
    cnt_n  = cnt;
    done_n = done;
    if (grant) begin
      ptr_n = ptr + AW'(step);
      cnt_n = cnt - CW'(1);
      if (cnt == CW'(1)) done_n = 1'b1;
    end
    if (wr_ptr) ptr_n = wdata;
    if (wr_cnt) begin
      cnt_n = wdata[CW-1:0];
      if (wdata[CW-1:0] != '0) done_n = 1'b0;
    end
    pend_n = (cnt_n != '0) && ((pend && !grant) || rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
      done  <= 1'b0;
    end else begin
      req_q <= req;
      pend  <= pend_n;
      done  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else begin
      if (ptr_en) ptr <= ptr_n;
      if (cnt_en) cnt <= cnt_n;
    end
  end

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !wr_ptr) |=> ptr == $past(ptr) + AW'($past(step)));
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !wr_cnt) |=> cnt == $past(cnt) - CW'(1));
  assert_no_grant_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> cnt != '0);
  assert_done_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == '0);
endmodule

// File: rtl/pdc_regif.sv
module pdc_regif
  import pdc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                         reg_wr,
  input  logic [1:0]                   reg_addr,
  input  logic [NUM_CH-1:0][AW-1:0]    ptrs,
  input  logic [NUM_CH-1:0][CW-1:0]    cnts,
  output logic [NUM_CH-1:0]            wr_ptr,
  output logic [NUM_CH-1:0]            wr_cnt,
  output logic [AW-1:0]                reg_rdata
);
  localparam int PADW = AW - CW;

  logic     ch_sel;
  fld_sel_e fld;

  assign ch_sel = reg_addr[1];
  assign fld    = fld_sel_e'(reg_addr[0]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign wr_ptr[i] = reg_wr && (ch_sel == 1'(i)) && (fld == FLD_PTR);
    assign wr_cnt[i] = reg_wr && (ch_sel == 1'(i)) && (fld == FLD_CNT);
  end

  always_comb begin
    if (fld == FLD_PTR) reg_rdata = ptrs[ch_sel];
    else                reg_rdata = {{PADW{1'b0}}, cnts[ch_sel]};
  end
endmodule

// File: rtl/pdc_mem_port.sv
module pdc_mem_port #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_pend,
  input  logic          tx_pend,
  input  logic          rx_rise,
  input  logic [DW-1:0] rx_data,
  input  logic [AW-1:0] rx_ptr,
  input  logic [AW-1:0] tx_ptr,
  input  logic [DW-1:0] mem_rdata,
  output logic          rx_grant,
  output logic          tx_grant,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid
);
  logic [DW-1:0] rx_buf;
  logic          rd_wait;

  assign rx_grant  = rx_pend;
  assign tx_grant  = tx_pend & ~rx_pend;
  assign mem_valid = rx_grant | tx_grant;
  assign mem_write = rx_grant;
  assign mem_addr  = rx_grant ? rx_ptr : tx_ptr;
  assign mem_wdata = rx_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wait  <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      rd_wait  <= tx_grant;
      tx_valid <= rd_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      tx_data <= '0;
    end else begin
      if (rx_rise) rx_buf  <= rx_data;
      if (rd_wait) tx_data <= mem_rdata;
    end
  end

  assert_txv_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(mem_valid && !mem_write, 2));
endmodule

// File: rtl/pdc_pair.sv
module pdc_pair
  import pdc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          unit_wide,
  input  logic          rx_req,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_req,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic          rx_done,
  output logic          tx_done,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic [NUM_CH-1:0][AW-1:0] ch_ptr;
  logic [NUM_CH-1:0][CW-1:0] ch_cnt;
  logic [NUM_CH-1:0]         ch_req, ch_grant, ch_pend, ch_done, ch_rise;
  logic [NUM_CH-1:0]         wr_ptr, wr_cnt;
  logic [1:0]                step;

  assign step           = unit_wide ? 2'd2 : 2'd1;
  assign ch_req[CH_RX]  = rx_req;
  assign ch_req[CH_TX]  = tx_req;
  assign rx_done        = ch_done[CH_RX];
  assign tx_done        = ch_done[CH_TX];

  pdc_regif #(.AW(AW), .CW(CW)) u_regif (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ptrs      (ch_ptr),
    .cnts      (ch_cnt),
    .wr_ptr    (wr_ptr),
    .wr_cnt    (wr_cnt),
    .reg_rdata (reg_rdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pdc_channel #(.AW(AW), .CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (ch_req[i]),
      .grant  (ch_grant[i]),
      .wr_ptr (wr_ptr[i]),
      .wr_cnt (wr_cnt[i]),
      .wdata  (reg_wdata),
      .step   (step),
      .ptr    (ch_ptr[i]),
      .cnt    (ch_cnt[i]),
      .pend   (ch_pend[i]),
      .done   (ch_done[i]),
      .rise   (ch_rise[i])
    );
  end

  pdc_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_pend   (ch_pend[CH_RX]),
    .tx_pend   (ch_pend[CH_TX]),
    .rx_rise   (ch_rise[CH_RX]),
    .rx_data   (rx_data),
    .rx_ptr    (ch_ptr[CH_RX]),
    .tx_ptr    (ch_ptr[CH_TX]),
    .mem_rdata (mem_rdata),
    .rx_grant  (ch_grant[CH_RX]),
    .tx_grant  (ch_grant[CH_TX]),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid)
  );

  assert_rx_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pend[CH_RX] && ch_pend[CH_TX]) |-> (mem_valid && mem_write));
  assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_grant));
endmodule

// File: tb/pdc_pair_test.sv
module pdc_pair_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        unit_wide;
  logic        rx_req;
  logic [15:0] rx_data;
  logic        tx_req;
  logic [15:0] tx_data;
  logic        tx_valid;
  logic        rx_done, tx_done;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  pdc_pair uut (.*);

  // memory: read data returns one cycle after the read request
  always @(posedge clk) begin
    if (!rst_n) mem_rdata <= 16'h0;
    else if (mem_valid && !mem_write) mem_rdata <= mem_addr[15:0] ^ 16'h5A3C;
  end

  // access log
  bit acc_kind[$];
  always @(posedge clk) if (rst_n && mem_valid) acc_kind.push_back(mem_write);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ptr [2];
  logic [15:0] m_cnt [2];
  bit          m_done [2];
  bit          m_pend [2];
  bit          m_reqq [2];
  logic [15:0] m_buf, m_txd;
  bit          m_rdw, m_txv;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ptr[c] = 0; m_cnt[c] = 0; m_done[c] = 0; m_pend[c] = 0; m_reqq[c] = 0;
      end
      m_buf = 0; m_txd = 0; m_rdw = 0; m_txv = 0;
    end else begin
      int g;
      bit rq [2];
      rq[0] = rx_req; rq[1] = tx_req;
      g = m_pend[0] ? 0 : (m_pend[1] ? 1 : -1);
      m_txv = m_rdw;
      if (m_rdw) m_txd = mem_rdata;
      m_rdw = (g == 1);
      for (int c = 0; c < 2; c++) begin
        bit rise, kept;
        rise = rq[c] && !m_reqq[c];
        m_reqq[c] = rq[c];
        if (c == 0 && rise) m_buf = rx_data;
        kept = m_pend[c] && (g != c);
        if (g == c) begin
          m_ptr[c] = m_ptr[c] + (unit_wide ? 2 : 1);
          if (m_cnt[c] == 1) m_done[c] = 1;
          m_cnt[c] = m_cnt[c] - 1;
        end
        if (reg_wr && reg_addr == 2'(2 * c)) m_ptr[c] = reg_wdata;
        if (reg_wr && reg_addr == 2'(2 * c + 1)) begin
          m_cnt[c] = reg_wdata[15:0];
          if (reg_wdata[15:0] != 0) m_done[c] = 0;
        end
        m_pend[c] = (m_cnt[c] != 0) && (kept || rise);
      end
    end
    #2;
    if (!ended) compare();
  end

  task automatic compare();
    bit ev;
    logic [31:0] er;
    string rt;
    rt = rst_n ? "R3/R7" : "R1";
    ev = m_pend[0] || m_pend[1];
    check(mem_valid === ev, rt, "mem_valid", 32'(mem_valid), 32'(ev));
    if (ev) begin
      check(mem_write === m_pend[0], "R10", "mem_write", 32'(mem_write), 32'(m_pend[0]));
      check(mem_addr === (m_pend[0] ? m_ptr[0] : m_ptr[1]), "R5", "mem_addr",
            mem_addr, m_pend[0] ? m_ptr[0] : m_ptr[1]);
      if (m_pend[0])
        check(mem_wdata === m_buf, "R3", "mem_wdata", 32'(mem_wdata), 32'(m_buf));
    end
    check(tx_valid === m_txv, rst_n ? "R4" : "R1", "tx_valid", 32'(tx_valid), 32'(m_txv));
    if (m_txv) check(tx_data === m_txd, "R4", "tx_data", 32'(tx_data), 32'(m_txd));
    check(rx_done === m_done[0], rst_n ? "R6" : "R1", "rx_done", 32'(rx_done), 32'(m_done[0]));
    check(tx_done === m_done[1], rst_n ? "R6" : "R1", "tx_done", 32'(tx_done), 32'(m_done[1]));
    er = reg_addr[0] ? {16'h0, m_cnt[reg_addr[1]]} : m_ptr[reg_addr[1]];
    check(reg_rdata === er, rst_n ? "R2" : "R1", "reg_rdata", reg_rdata, er);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input bit rx, input bit tx, input logic [15:0] d, input int hold);
    @(negedge clk);
    rx_req = rx; tx_req = tx; rx_data = d;
    repeat (hold) @(negedge clk);
    rx_req = 1'b0; tx_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = 0;
    unit_wide = 1'b0; rx_req = 1'b0; tx_req = 1'b0; rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_valid === 1'b0 && rx_done === 1'b0 && tx_done === 1'b0, "R1",
          "idle after reset", {30'h0, rx_done, mem_valid}, 0);

    wr(2'd0, 32'h0000_1000);
    wr(2'd1, 32'hABCD_0003);
    wr(2'd2, 32'h0000_2000);
    wr(2'd3, 32'h0000_0002);
    reg_addr = 2'd1;
    @(negedge clk);
    check(reg_rdata === 32'h3, "R2", "count upper bits ignored", reg_rdata, 32'h3);

    // receive, narrow then wide units
    pulse(1, 0, 16'h0011, 1);
    unit_wide = 1'b1;
    pulse(1, 0, 16'h0022, 1);
    reg_addr = 2'd0;
    @(negedge clk);
    check(reg_rdata === 32'h1003, "R5", "rx pointer after 1+2", reg_rdata, 32'h1003);
    unit_wide = 1'b0;

    // transmit until empty
    pulse(0, 1, 0, 1);
    pulse(0, 1, 0, 1);
    check(tx_done === 1'b1, "R6", "tx_done at zero", 32'(tx_done), 1);

    // zero count ignores requests
    n = acc_kind.size();
    pulse(0, 1, 0, 1);
    check(acc_kind.size() == n, "R7", "no access at zero count", acc_kind.size(), n);

    // held request served once
    n = acc_kind.size();
    pulse(1, 0, 16'h0033, 6);
    check(acc_kind.size() == n + 1, "R9", "held request accesses", acc_kind.size(), n + 1);
    check(rx_done === 1'b1, "R6", "rx_done at zero", 32'(rx_done), 1);

    // re-arm
    wr(2'd1, 32'h0000_0004);
    wr(2'd3, 32'h0000_0004);
    @(negedge clk);
    check(rx_done === 1'b0 && tx_done === 1'b0, "R8", "done cleared by rewrite",
          {30'h0, tx_done, rx_done}, 0);

    // simultaneous requests
    n = acc_kind.size();
    pulse(1, 1, 16'h0044, 1);
    check(acc_kind.size() == n + 2, "R10", "both served", acc_kind.size(), n + 2);
    if (acc_kind.size() == n + 2) begin
      check(acc_kind[n] == 1'b1, "R10", "first access is write", 32'(acc_kind[n]), 1);
      check(acc_kind[n + 1] == 1'b0, "R10", "second access is read", 32'(acc_kind[n + 1]), 0);
    end

    // wide transmit and cancel by zero count
    unit_wide = 1'b1;
    pulse(0, 1, 0, 1);
    reg_addr = 2'd2;
    @(negedge clk);
    check(reg_rdata === 32'h2005, "R5", "tx pointer wide step", reg_rdata, 32'h2005);
    unit_wide = 1'b0;
    n = acc_kind.size();
    @(negedge clk);
    rx_req = 1'b1; rx_data = 16'h0055;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
    @(negedge clk);
    rx_req = 1'b0; reg_wr = 1'b0;
    repeat (4) @(negedge clk);
    check(acc_kind.size() == n, "R7", "zero count cancels request", acc_kind.size(), n);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule